// File: doc/BRIEF.md
# Predecode-Woken Low-Leakage Register File

This block is a register file with two read ports and one write port. Each register row has its own power state, either drowsy or awake. A drowsy row keeps its contents, but its read and write enables are blocked. The supply switching itself is represented only by a per-row awake bit.

The fetch stage hands over the raw instruction word. Three register-index fields are cut from fixed bit positions of that word, with no further decoding, and each named row is awake from the next clock edge. So the row is ready for the decode-stage read in the following cycle. The writeback destination has its own wake input, which the pipeline raises one cycle before it writes. An awake row falls back to drowsy one cycle after it was woken, unless it is woken again in that cycle.

A small set of reserved indices stays awake at all times. Two counters record how many rows were woken and how many of them went back to sleep without any read or write. Those wasted wakes come from fields that are really immediates or addresses. Any attempt to reach a drowsy row sets a sticky violation flag.

Top module: `drowsy_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, the following happens. Every row is cleared to zero. The awake mask becomes exactly the reserved set. Both counters return to zero and the violation flag clears.
- R2: When `fetch_valid` is high, the row indices are taken from fixed bit fields of `fetch_instr`: bits [25:21], bits [20:16] and bits [15:11]. Every row named in those fields is awake after the next clock edge, whether or not the field is really a register operand. No other bit of the word wakes anything.
- R3: A non-reserved row is awake for exactly one cycle after the edge that woke it. It is drowsy after the following edge unless a wake for it was presented during that awake cycle.
- R4: The reserved indices 0, 29, 31 and 2 are always awake. They can always be read and written. A wake aimed at them changes no counter.
- R5: Reads are registered. A read of an awake row shows that row's contents on its data output one cycle later. A read and a write of the same row in the same cycle return the old contents.
- R6: A read of a drowsy row returns zero one cycle later and sets the violation flag.
- R7: A write to an awake row stores the data. A write to a drowsy row leaves the row unchanged and sets the violation flag.
- R8: When `dest_wake_valid` is high, row `dest_wake_addr` is awake after the next clock edge. That row can be written in the following cycle.
- R9: `wake_count` rises by the number of distinct non-reserved rows that go from drowsy to awake at an edge. Waking a row that is already awake adds nothing.
- R10: `waste_count` rises by the number of non-reserved rows that go from awake to drowsy at an edge without any granted read or write during their awake span.
- R11: `access_violation` stays high once set, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetched instruction word is present |
| fetch_instr | input | 32 | Raw fetched instruction word |
| dest_wake_valid | input | 1 | Wake request for the writeback destination |
| dest_wake_addr | input | 5 | Destination row to wake |
| rd_en_a | input | 1 | Read request, port A |
| rd_addr_a | input | 5 | Row index, port A |
| rd_data_a | output | 32 | Registered read data, port A |
| rd_en_b | input | 1 | Read request, port B |
| rd_addr_b | input | 5 | Row index, port B |
| rd_data_b | output | 32 | Registered read data, port B |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Row index to write |
| wr_data | input | 32 | Write data |
| active_mask | output | 32 | Awake bit of every row |
| wake_count | output | 16 | Rows woken since reset |
| waste_count | output | 16 | Woken rows that returned to drowsy unused |
| access_violation | output | 1 | Sticky flag for blocked accesses |

## Verification
The assertions take for granted that the row count is a power of two, so every 5-bit index names a real row. They also take for granted that no input is unknown once reset is released. Their window checks assume that wakes, reads and writes are applied as whole-cycle pulses.

The stimulus changes inputs only at the falling clock edge and keeps every index below 32. It reaches the gated paths deliberately: drowsy reads and writes, a row woken twice in a row, repeated and reserved fields in one word, and a same-cycle read and write of one row. Before each check it waits for the registered outputs to settle.

// File: rtl/drf_pkg.sv
package drf_pkg;

  localparam int MAX_ROWS = 256;

  // Build the mask of rows that never go drowsy.
  function automatic logic [MAX_ROWS-1:0] keep_mask(input int k0, input int k1,
                                                    input int k2, input int k3);
    logic [MAX_ROWS-1:0] m;
    m = '0;
    m[k0] = 1'b1;
    m[k1] = 1'b1;
    m[k2] = 1'b1;
    m[k3] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/drf_predecode.sv
module drf_predecode #(
  parameter int NUM_ROWS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fld_s,
  input  logic [ADDR_W-1:0]   fld_t,
  input  logic [ADDR_W-1:0]   fld_d,
  input  logic                dest_wake_valid,
  input  logic [ADDR_W-1:0]   dest_wake_addr,
  input  logic [NUM_ROWS-1:0] keep_rows,
  output logic [NUM_ROWS-1:0] wake_vec
);

  logic [NUM_ROWS-1:0] raw;

  // Assume a three-operand shape: every field wakes its row.
  always_comb begin
    raw = '0;
    if (fetch_valid) begin
      raw[fld_s] = 1'b1;
      raw[fld_t] = 1'b1;
      raw[fld_d] = 1'b1;
    end
    if (dest_wake_valid) raw[dest_wake_addr] = 1'b1;
    wake_vec = raw & ~keep_rows;
  end

endmodule

// File: rtl/drf_power_ctrl.sv
module drf_power_ctrl #(
  parameter int                     NUM_ROWS  = 32,
  parameter int                     CNT_W     = 16,
  parameter logic [NUM_ROWS-1:0]    KEEP_ROWS = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] wake_vec,
  input  logic [NUM_ROWS-1:0] access_vec,
  output logic [NUM_ROWS-1:0] active,
  output logic [CNT_W-1:0]    wake_cnt,
  output logic [CNT_W-1:0]    waste_cnt
);

  logic [NUM_ROWS-1:0] used;
  logic [NUM_ROWS-1:0] active_n;
  logic [NUM_ROWS-1:0] rises;
  logic [NUM_ROWS-1:0] falls_idle;
  logic [NUM_ROWS-1:0] used_n;

  always_comb begin
    active_n   = KEEP_ROWS | wake_vec;
    rises      = active_n & ~active & ~KEEP_ROWS;
    falls_idle = active & ~active_n & ~KEEP_ROWS & ~(used | access_vec);
    used_n     = (used | access_vec) & active & active_n & ~KEEP_ROWS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= KEEP_ROWS;
      used      <= '0;
      wake_cnt  <= '0;
      waste_cnt <= '0;
    end else begin
      active    <= active_n;
      used      <= used_n;
      wake_cnt  <= wake_cnt + CNT_W'($countones(rises));
      waste_cnt <= waste_cnt + CNT_W'($countones(falls_idle));
    end
  end

  // R4: reserved rows stay awake
  a_r4_keep_awake: assert property (@(posedge clk) disable iff (rst)
    (active & KEEP_ROWS) == KEEP_ROWS);

  // R3: a non-reserved row is awake only in the cycle after its wake
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((active & ~KEEP_ROWS) == ($past(wake_vec) & ~KEEP_ROWS)));

  // R9: no wake request, no growth of the wake counter
  a_r9_wake_quiet: assert property (@(posedge clk) disable iff (rst)
    (wake_vec == '0) |=> $stable(wake_cnt));

  // R10: nothing awake outside the reserved set, nothing to waste
  a_r10_waste_quiet: assert property (@(posedge clk) disable iff (rst)
    ((active & ~KEEP_ROWS) == '0) |=> $stable(waste_cnt));

endmodule

// File: rtl/drf_storage.sv
module drf_storage #(
  parameter int NUM_ROWS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] active,
  input  logic                rd_en_a,
  input  logic [ADDR_W-1:0]   rd_addr_a,
  input  logic                rd_en_b,
  input  logic [ADDR_W-1:0]   rd_addr_b,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data_a,
  output logic [DATA_W-1:0]   rd_data_b,
  output logic                violation,
  output logic [NUM_ROWS-1:0] access_vec
);

  logic [DATA_W-1:0] rows [NUM_ROWS];
  logic grant_a, grant_b, grant_w, blocked;

  always_comb begin
    grant_a = rd_en_a && active[rd_addr_a];
    grant_b = rd_en_b && active[rd_addr_b];
    grant_w = wr_en   && active[wr_addr];
    blocked = (rd_en_a && !grant_a) || (rd_en_b && !grant_b) || (wr_en && !grant_w);
    access_vec = '0;
    if (grant_a) access_vec[rd_addr_a] = 1'b1;
    if (grant_b) access_vec[rd_addr_b] = 1'b1;
    if (grant_w) access_vec[wr_addr]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ROWS; i++) rows[i] <= '0;
      rd_data_a <= '0;
      rd_data_b <= '0;
      violation <= 1'b0;
    end else begin
      if (grant_w) rows[wr_addr] <= wr_data;
      rd_data_a <= grant_a ? rows[rd_addr_a] : '0;
      rd_data_b <= grant_b ? rows[rd_addr_b] : '0;
      violation <= violation | blocked;
    end
  end

  // R6: drowsy read yields zero
  a_r6_drowsy_read_a: assert property (@(posedge clk) disable iff (rst)
    (rd_en_a && !active[rd_addr_a]) |=> (rd_data_a == '0));
  a_r6_drowsy_read_b: assert property (@(posedge clk) disable iff (rst)
    (rd_en_b && !active[rd_addr_b]) |=> (rd_data_b == '0));

  // R5: awake read returns the stored word
  a_r5_awake_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en_a && active[rd_addr_a]) |=> (rd_data_a == $past(rows[rd_addr_a])));

  // R7: drowsy write leaves the row untouched
  a_r7_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !active[wr_addr]) |=> (rows[$past(wr_addr)] == $past(rows[wr_addr])));

  // R11: violation is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

endmodule

// File: rtl/drowsy_regfile.sv
module drowsy_regfile #(
  parameter int NUM_ROWS = 32,
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int FS_LSB   = 21,
  parameter int FT_LSB   = 16,
  parameter int FD_LSB   = 11,
  parameter int KEEP_A   = 0,
  parameter int KEEP_B   = 29,
  parameter int KEEP_C   = 31,
  parameter int KEEP_D   = 2,
  parameter int CNT_W    = 16,
  localparam int ADDR_W  = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_valid,
  input  logic [INSTR_W-1:0]  fetch_instr,
  input  logic                dest_wake_valid,
  input  logic [ADDR_W-1:0]   dest_wake_addr,
  input  logic                rd_en_a,
  input  logic [ADDR_W-1:0]   rd_addr_a,
  output logic [DATA_W-1:0]   rd_data_a,
  input  logic                rd_en_b,
  input  logic [ADDR_W-1:0]   rd_addr_b,
  output logic [DATA_W-1:0]   rd_data_b,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_ROWS-1:0] active_mask,
  output logic [CNT_W-1:0]    wake_count,
  output logic [CNT_W-1:0]    waste_count,
  output logic                access_violation
);

  localparam logic [drf_pkg::MAX_ROWS-1:0] KEEP_FULL =
    drf_pkg::keep_mask(KEEP_A, KEEP_B, KEEP_C, KEEP_D);
  localparam logic [NUM_ROWS-1:0] KEEP_ROWS = KEEP_FULL[NUM_ROWS-1:0];

  logic [ADDR_W-1:0]   fld_s, fld_t, fld_d;
  logic [NUM_ROWS-1:0] wake_vec;
  logic [NUM_ROWS-1:0] access_vec;

  assign fld_s = fetch_instr[FS_LSB +: ADDR_W];
  assign fld_t = fetch_instr[FT_LSB +: ADDR_W];
  assign fld_d = fetch_instr[FD_LSB +: ADDR_W];

  drf_predecode #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_predecode (
    .fetch_valid     (fetch_valid),
    .fld_s           (fld_s),
    .fld_t           (fld_t),
    .fld_d           (fld_d),
    .dest_wake_valid (dest_wake_valid),
    .dest_wake_addr  (dest_wake_addr),
    .keep_rows       (KEEP_ROWS),
    .wake_vec        (wake_vec)
  );

  drf_power_ctrl #(.NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W), .KEEP_ROWS(KEEP_ROWS)) u_power (
    .clk        (clk),
    .rst        (rst),
    .wake_vec   (wake_vec),
    .access_vec (access_vec),
    .active     (active_mask),
    .wake_cnt   (wake_count),
    .waste_cnt  (waste_count)
  );

  drf_storage #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_storage (
    .clk        (clk),
    .rst        (rst),
    .active     (active_mask),
    .rd_en_a    (rd_en_a),
    .rd_addr_a  (rd_addr_a),
    .rd_en_b    (rd_en_b),
    .rd_addr_b  (rd_addr_b),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_data_a  (rd_data_a),
    .rd_data_b  (rd_data_b),
    .violation  (access_violation),
    .access_vec (access_vec)
  );

  // R2: every fetched field is awake after the next edge
  a_r2_wake_s: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> active_mask[$past(fld_s)]);
  a_r2_wake_d: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> active_mask[$past(fld_d)]);

  // R8: destination wake reaches the mask
  a_r8_dest_wake: assert property (@(posedge clk) disable iff (rst)
    dest_wake_valid |=> active_mask[$past(dest_wake_addr)]);

endmodule

// File: tb/test_drowsy_regfile.sv
`timescale 1ns/1ps
module test_drowsy_regfile;

  localparam logic [31:0] KEEP = (32'h1 << 0) | (32'h1 << 29) | (32'h1 << 31) | (32'h1 << 2);

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid;
  logic [31:0] fetch_instr;
  logic        dest_wake_valid;
  logic [4:0]  dest_wake_addr;
  logic        rd_en_a, rd_en_b, wr_en;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data_a, rd_data_b;
  logic [31:0] active_mask;
  logic [15:0] wake_count, waste_count;
  logic        access_violation;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t qa[$];
  exp_t qb[$];
  logic pend_a = 1'b0;
  logic pend_b = 1'b0;

  always #2.5 clk = ~clk;

  drowsy_regfile i_drowsy_regfile (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .dest_wake_valid(dest_wake_valid), .dest_wake_addr(dest_wake_addr),
    .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .active_mask(active_mask), .wake_count(wake_count), .waste_count(waste_count),
    .access_violation(access_violation)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int s, input int t, input int d);
    return {6'h2A, 5'(s), 5'(t), 5'(d), 11'h7FF};
  endfunction

  function automatic logic [31:0] bit_of(input int i);
    return 32'h1 << i;
  endfunction

  task automatic idle();
    fetch_valid = 0; dest_wake_valid = 0; rd_en_a = 0; rd_en_b = 0; wr_en = 0;
  endtask

  task automatic drv_fetch(input logic [31:0] w);
    fetch_valid = 1; fetch_instr = w;
  endtask

  task automatic drv_rd_a(input int a, input logic [31:0] e, input string tag);
    exp_t x;
    rd_en_a = 1; rd_addr_a = 5'(a);
    x.data = e; x.tag = tag; qa.push_back(x);
  endtask

  task automatic drv_rd_b(input int a, input logic [31:0] e, input string tag);
    exp_t x;
    rd_en_b = 1; rd_addr_b = 5'(a);
    x.data = e; x.tag = tag; qb.push_back(x);
  endtask

  task automatic drv_wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 5'(a); wr_data = d;
  endtask

  // Monitor: note issued reads at the edge, compare half a cycle later
  always @(posedge clk) begin
    pend_a <= rd_en_a & ~rst;
    pend_b <= rd_en_b & ~rst;
  end

  always @(negedge clk) begin
    if (pend_a) begin
      if (qa.size() == 0) chk("scoreboard A empty", 1, 0);
      else begin exp_t e; e = qa.pop_front(); chk(e.tag, rd_data_a, e.data); end
    end
    if (pend_b) begin
      if (qb.size() == 0) chk("scoreboard B empty", 1, 0);
      else begin exp_t e; e = qb.pop_front(); chk(e.tag, rd_data_b, e.data); end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst = 1; fetch_instr = '0; dest_wake_addr = '0; rd_addr_a = '0; rd_addr_b = '0;
    wr_addr = '0; wr_data = '0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 mask", active_mask, KEEP);
    chk("R1 wake", wake_count, 0);
    chk("R1 waste", waste_count, 0);
    chk("R1 violation", access_violation, 0);
    drv_rd_a(29, 0, "R1 cleared row");
    @(negedge clk); idle();

    drv_wr(29, 32'hCAFE0029);
    @(negedge clk); idle();
    drv_rd_a(29, 32'hCAFE0029, "R4 reserved row written");
    @(negedge clk); idle();

    // R2: three fields wake three rows
    drv_fetch(mk(5, 6, 7));
    @(negedge clk); idle();
    chk("R2 mask", active_mask, KEEP | bit_of(5) | bit_of(6) | bit_of(7));
    chk("R9 wake", wake_count, 3);
    drv_rd_a(5, 0, "R5 awake read");
    drv_wr(7, 32'h1234_5678);
    @(negedge clk); idle();
    chk("R3 back drowsy", active_mask, KEEP);
    chk("R10 waste", waste_count, 1);
    chk("R11 clean", access_violation, 0);

    // R6: drowsy read on port B
    drv_rd_b(7, 0, "R6 drowsy read");
    @(negedge clk); idle();
    chk("R6 violation", access_violation, 1);

    // R8: destination wake, then read back the earlier write
    dest_wake_valid = 1; dest_wake_addr = 5'd7;
    @(negedge clk); idle();
    chk("R8 mask", active_mask, KEEP | bit_of(7));
    chk("R9 wake dest", wake_count, 4);
    drv_rd_a(7, 32'h1234_5678, "R7 awake write stored");
    drv_rd_b(31, 0, "R4 reserved read");
    @(negedge clk); idle();
    chk("R10 used row", waste_count, 1);
    chk("R11 still set", access_violation, 1);

    // R7: drowsy write is dropped
    drv_wr(9, 32'hDEAD_BEEF);
    @(negedge clk); idle();
    drv_fetch(mk(9, 10, 11));
    @(negedge clk); idle();
    chk("R9 wake three", wake_count, 7);
    drv_rd_a(9, 0, "R7 dropped write");
    @(negedge clk); idle();
    chk("R10 two idle", waste_count, 3);

    // R3/R9: re-wake keeps the row awake, counted once
    drv_fetch(mk(12, 0, 0));
    @(negedge clk);
    chk("R3 first wake", active_mask, KEEP | bit_of(12));
    chk("R9 first wake", wake_count, 8);
    @(negedge clk); idle();
    chk("R3 re-woken", active_mask, KEEP | bit_of(12));
    chk("R9 re-wake uncounted", wake_count, 8);
    @(negedge clk);
    chk("R3 asleep", active_mask, KEEP);
    chk("R10 re-woken idle", waste_count, 4);

    // R4: reserved fields change nothing
    drv_fetch(mk(0, 29, 2));
    @(negedge clk); idle();
    chk("R4 mask", active_mask, KEEP);
    chk("R4 wake", wake_count, 8);
    @(negedge clk);
    chk("R4 waste", waste_count, 4);

    // R9: repeated field counts once
    drv_fetch(mk(14, 14, 14));
    @(negedge clk); idle();
    chk("R9 duplicate", wake_count, 9);
    @(negedge clk);
    chk("R10 duplicate", waste_count, 5);

    // R5: same-cycle read and write returns old data
    drv_wr(29, 32'h0BAD_F00D);
    drv_rd_a(29, 32'hCAFE0029, "R5 old data");
    @(negedge clk); idle();
    drv_rd_a(29, 32'h0BAD_F00D, "R5 new data");
    @(negedge clk); idle();

    // R1/R11: reset clears flag, counters and rows
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R11 cleared by reset", access_violation, 0);
    chk("R1 counters", {wake_count, waste_count}, 0);
    drv_rd_a(29, 0, "R1 row cleared");
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    chk("scoreboard drained", qa.size() + qb.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule